// File: doc/BRIEF.md
# Programmable Video Timing Strobe Generator

This block produces the per-pixel timing strobes that pace an overlay data interface feeding a video encoder. Two counters, advanced by the pixel clock, track the pixel within the current line and the line within the current frame. From those positions and a set of configuration inputs it derives six registered outputs: a field identifier, a one-line vertical sync, a vertical blank level, a horizontal sync of programmable start and width, a short horizontal blank marker, and an active-video qualifier. The source that receives the qualifier places a pixel on the 30-bit (3 x 10-bit) data bus one clock after it sees the qualifier high.

Configuration inputs are copied into a shadow set while the block is disabled and again on the last pixel of every frame. A change made in the middle of a frame therefore applies from the next frame on. Interlaced timing divides each frame into two fields at a programmable last line of field 1. Each field has its own active-line window. Progressive timing uses a single window per frame.

A small field-tracking state machine has three states. OFF is held while the enable is low. FIELD1 covers line 0 up to the field-1 last line, and covers the whole frame in progressive mode. FIELD2 covers the lines after the field-1 last line in interlaced mode. The transitions are named as follows. START is OFF to FIELD1 when the enable rises. SPLIT is FIELD1 to FIELD2 on the last pixel of the field-1 last line, and occurs only in interlaced mode. WRAP is FIELD1 or FIELD2 to FIELD1 on the last pixel of the frame. STOP is any state to OFF when the enable is low.

Top module: `dtg_top`

## Requirements
- R1: While reset is asserted, and after it is released with the enable low, all six strobe outputs are 0.
- R2: While the enable is low the outputs are 0 in the following clock cycle. When the enable rises, the first outputs describe pixel 0 of line 0 of field 1, with field ID 0.
- R3: The pixel counter runs from 0 to total-pixels minus 1 and then wraps, so every line lasts exactly total-pixels clocks. The line counter wraps after total-lines minus 1.
- R4: Field ID is 0 for the first field after the enable rises. It toggles at the start of every field when interlaced and at the start of every frame when progressive.
- R5: Vertical sync is high for exactly one whole line. That line is line 0, plus, when interlaced, the line after the field-1 last line.
- R6: Vertical blank is 0 on lines inside the active window of the current field, [first, end). It is 1 on all other lines. Field 2 uses the second window.
- R7: Horizontal sync is high on pixels p where start <= p < start + width, on every line.
- R8: The horizontal blank marker is high for exactly 4 pixels per line, pixels p where position <= p < position + 4.
- R9: Active video is high when the line is inside the current field's active window and the pixel p satisfies first <= p < end.
- R10: Configuration changes take effect only from pixel 0 of line 0 of the next frame, or immediately while the enable is low.
- R11: Each output for a pixel appears one clock after the counters reach that pixel, and changes only on the rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable; low holds counters at 0 and outputs low |
| cfg_interlace | input | 1 | 1 = two fields per frame, 0 = progressive |
| cfg_h_total | input | 12 | Pixels per line |
| cfg_v_total | input | 11 | Lines per frame |
| cfg_f1_last | input | 11 | Last line of field 1 |
| cfg_hs_start | input | 12 | First pixel of horizontal sync |
| cfg_hs_width | input | 12 | Horizontal sync width in pixels |
| cfg_mark_pos | input | 12 | First pixel of the 4-pixel blank marker |
| cfg_hact_first | input | 12 | First active pixel |
| cfg_hact_end | input | 12 | One past the last active pixel |
| cfg_act1_first | input | 11 | First active line, field 1 or progressive frame |
| cfg_act1_end | input | 11 | One past the last active line, field 1 |
| cfg_act2_first | input | 11 | First active line, field 2 |
| cfg_act2_end | input | 11 | One past the last active line, field 2 |
| fid_o | output | 1 | Field identifier |
| vsync_o | output | 1 | One-line vertical sync |
| vblank_o | output | 1 | Vertical blank level |
| hsync_o | output | 1 | Horizontal sync |
| hmark_o | output | 1 | Four-pixel horizontal blank marker |
| actvid_o | output | 1 | Active-video qualifier |

## Verification
The assertions rely on a few limits for the configuration. Total pixels is at least 5. The marker and sync windows end within the line. The field-1 last line lies before the final line of the frame. The enable stays low for at least one clock after reset, so the shadow set is loaded before counting starts. Every configuration the stimulus applies keeps to these limits, and that includes the one rewritten in the middle of a frame. Expected strobes come from a pixel-by-pixel model of the requirements. The model copies its own configuration only at frame ends and while disabled.

// File: rtl/dtg_pkg.sv
package dtg_pkg;
    parameter int unsigned HW       = 12;
    parameter int unsigned VW       = 11;
    parameter int unsigned MARK_LEN = 4;

    typedef logic [HW-1:0] hpos_t;
    typedef logic [HW:0]   hext_t;
    typedef logic [VW-1:0] vpos_t;

    typedef enum logic [1:0] {
        ST_OFF = 2'd0,
        ST_F1  = 2'd1,
        ST_F2  = 2'd2
    } field_st_e;

    typedef struct packed {
        logic  interlace;
        hpos_t h_total;
        vpos_t v_total;
        vpos_t f1_last;
        hpos_t hs_start;
        hpos_t hs_width;
        hpos_t mark_pos;
        hpos_t hact_first;
        hpos_t hact_end;
        vpos_t act1_first;
        vpos_t act1_end;
        vpos_t act2_first;
        vpos_t act2_end;
    } dtg_cfg_t;
endpackage

// File: rtl/dtg_shadow.sv
module dtg_shadow
    import dtg_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     load_i,
    input  dtg_cfg_t cfg_d_i,
    output dtg_cfg_t cfg_q_o
);
    dtg_cfg_t cfg_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (load_i) begin
            cfg_q <= cfg_d_i;
        end
    end

    assign cfg_q_o = cfg_q;

    // Between loads the shadow set must not move (R10)
    assert_shadow_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(cfg_q));
endmodule

// File: rtl/dtg_scan.sv
module dtg_scan
    import dtg_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      en_i,
    input  dtg_cfg_t  cfg_i,
    output hpos_t     h_o,
    output vpos_t     v_o,
    output field_st_e state_o,
    output logic      fid_o,
    output logic      frame_end_o
);
    localparam hpos_t H_ONE = hpos_t'(1);
    localparam vpos_t V_ONE = vpos_t'(1);

    field_st_e st_q, st_d;
    hpos_t     h_q, h_d;
    vpos_t     v_q, v_d;
    logic      fid_q, fid_d;
    logic      h_last, v_last, frame_end, split;

    always_comb begin
        h_last    = (h_q == cfg_i.h_total - H_ONE);
        v_last    = (v_q == cfg_i.v_total - V_ONE);
        frame_end = h_last && v_last;
        split     = cfg_i.interlace && h_last && (v_q == cfg_i.f1_last);
    end

    // Field state transitions: START, SPLIT, WRAP, STOP
    always_comb begin
        st_d = st_q;
        if (!en_i) begin
            st_d = ST_OFF;                          // STOP
        end else begin
            unique case (st_q)
                ST_OFF: st_d = ST_F1;               // START
                ST_F1: begin
                    if (frame_end)  st_d = ST_F1;   // WRAP
                    else if (split) st_d = ST_F2;   // SPLIT
                    else            st_d = ST_F1;
                end
                ST_F2: begin
                    if (frame_end)  st_d = ST_F1;   // WRAP
                    else            st_d = ST_F2;
                end
                default: st_d = ST_OFF;
            endcase
        end
    end

    // Position and field-ID next values
    always_comb begin
        if (!en_i) begin
            h_d   = '0;
            v_d   = '0;
            fid_d = 1'b0;
        end else begin
            h_d   = h_last ? '0 : h_q + H_ONE;
            v_d   = h_last ? (v_last ? '0 : v_q + V_ONE) : v_q;
            fid_d = fid_q;
            if (st_q != ST_OFF) begin
                if (frame_end || (st_q == ST_F1 && split)) begin
                    fid_d = ~fid_q;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_OFF;
            h_q   <= '0;
            v_q   <= '0;
            fid_q <= 1'b0;
        end else begin
            st_q  <= st_d;
            h_q   <= h_d;
            v_q   <= v_d;
            fid_q <= fid_d;
        end
    end

    assign h_o         = h_q;
    assign v_o         = v_q;
    assign state_o     = st_q;
    assign fid_o       = fid_q;
    assign frame_end_o = frame_end;

    assert_hpos_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_i.h_total >= hpos_t'(2)) |-> (h_q < cfg_i.h_total));
    assert_vpos_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_i.v_total >= vpos_t'(2)) |-> (v_q < cfg_i.v_total));
    assert_f2_needs_interlace_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_F2) |-> cfg_i.interlace);
    assert_fid_flip_on_split_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(st_q) == ST_F1 && st_q == ST_F2) |-> (fid_q != $past(fid_q)));
    assert_off_at_origin_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_OFF) |-> (h_q == '0 && v_q == '0 && !fid_q));
endmodule

// File: rtl/dtg_decode.sv
module dtg_decode
    import dtg_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      en_i,
    input  dtg_cfg_t  cfg_i,
    input  hpos_t     h_i,
    input  vpos_t     v_i,
    input  field_st_e state_i,
    input  logic      fid_i,
    output logic      fid_o,
    output logic      vsync_o,
    output logic      vblank_o,
    output logic      hsync_o,
    output logic      hmark_o,
    output logic      actvid_o
);
    localparam vpos_t V_ONE  = vpos_t'(1);
    localparam hext_t MARK_W = hext_t'(MARK_LEN);

    logic in_f2, vs_c, win_c, hs_c, mark_c, act_c;

    always_comb begin
        in_f2 = (state_i == ST_F2);
        vs_c  = (v_i == '0) || (in_f2 && (v_i == cfg_i.f1_last + V_ONE));
        win_c = in_f2 ? ((v_i >= cfg_i.act2_first) && (v_i < cfg_i.act2_end))
                      : ((v_i >= cfg_i.act1_first) && (v_i < cfg_i.act1_end));
        hs_c  = (h_i >= cfg_i.hs_start) &&
                ({1'b0, h_i} < ({1'b0, cfg_i.hs_start} + {1'b0, cfg_i.hs_width}));
        act_c = win_c && (h_i >= cfg_i.hact_first) && (h_i < cfg_i.hact_end);
    end

    generate
        if (MARK_LEN == 1) begin : g_mark_one
            assign mark_c = (h_i == cfg_i.mark_pos);
        end else begin : g_mark_span
            assign mark_c = (h_i >= cfg_i.mark_pos) &&
                            ({1'b0, h_i} < ({1'b0, cfg_i.mark_pos} + MARK_W));
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fid_o    <= 1'b0;
            vsync_o  <= 1'b0;
            vblank_o <= 1'b0;
            hsync_o  <= 1'b0;
            hmark_o  <= 1'b0;
            actvid_o <= 1'b0;
        end else if (!en_i) begin
            fid_o    <= 1'b0;
            vsync_o  <= 1'b0;
            vblank_o <= 1'b0;
            hsync_o  <= 1'b0;
            hmark_o  <= 1'b0;
            actvid_o <= 1'b0;
        end else begin
            fid_o    <= fid_i;
            vsync_o  <= vs_c;
            vblank_o <= ~win_c;
            hsync_o  <= hs_c;
            hmark_o  <= mark_c;
            actvid_o <= act_c;
        end
    end

    assert_quiet_when_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !(fid_o || vsync_o || vblank_o || hsync_o || hmark_o || actvid_o));

    generate
        if (MARK_LEN > 1) begin : g_mark_chk
            assert_mark_width_R8: assert property (@(posedge clk) disable iff (!rst_n)
                ($rose(hmark_o) && en_i) |=> hmark_o);
        end
    endgenerate
endmodule

// File: rtl/dtg_top.sv
module dtg_top
    import dtg_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          cfg_interlace,
    input  logic [HW-1:0] cfg_h_total,
    input  logic [VW-1:0] cfg_v_total,
    input  logic [VW-1:0] cfg_f1_last,
    input  logic [HW-1:0] cfg_hs_start,
    input  logic [HW-1:0] cfg_hs_width,
    input  logic [HW-1:0] cfg_mark_pos,
    input  logic [HW-1:0] cfg_hact_first,
    input  logic [HW-1:0] cfg_hact_end,
    input  logic [VW-1:0] cfg_act1_first,
    input  logic [VW-1:0] cfg_act1_end,
    input  logic [VW-1:0] cfg_act2_first,
    input  logic [VW-1:0] cfg_act2_end,
    output logic          fid_o,
    output logic          vsync_o,
    output logic          vblank_o,
    output logic          hsync_o,
    output logic          hmark_o,
    output logic          actvid_o
);
    dtg_cfg_t  cfg_raw, cfg_sh;
    hpos_t     h_pos;
    vpos_t     v_pos;
    field_st_e fstate;
    logic      fid_pos, frame_end, load;

    always_comb begin
        cfg_raw.interlace  = cfg_interlace;
        cfg_raw.h_total    = cfg_h_total;
        cfg_raw.v_total    = cfg_v_total;
        cfg_raw.f1_last    = cfg_f1_last;
        cfg_raw.hs_start   = cfg_hs_start;
        cfg_raw.hs_width   = cfg_hs_width;
        cfg_raw.mark_pos   = cfg_mark_pos;
        cfg_raw.hact_first = cfg_hact_first;
        cfg_raw.hact_end   = cfg_hact_end;
        cfg_raw.act1_first = cfg_act1_first;
        cfg_raw.act1_end   = cfg_act1_end;
        cfg_raw.act2_first = cfg_act2_first;
        cfg_raw.act2_end   = cfg_act2_end;
        load = !en || frame_end;
    end

    dtg_shadow u_shadow (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load),
        .cfg_d_i (cfg_raw),
        .cfg_q_o (cfg_sh)
    );

    dtg_scan u_scan (
        .clk         (clk),
        .rst_n       (rst_n),
        .en_i        (en),
        .cfg_i       (cfg_sh),
        .h_o         (h_pos),
        .v_o         (v_pos),
        .state_o     (fstate),
        .fid_o       (fid_pos),
        .frame_end_o (frame_end)
    );

    dtg_decode u_decode (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (en),
        .cfg_i    (cfg_sh),
        .h_i      (h_pos),
        .v_i      (v_pos),
        .state_i  (fstate),
        .fid_i    (fid_pos),
        .fid_o    (fid_o),
        .vsync_o  (vsync_o),
        .vblank_o (vblank_o),
        .hsync_o  (hsync_o),
        .hmark_o  (hmark_o),
        .actvid_o (actvid_o)
    );

    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !(vsync_o || hsync_o || actvid_o));
    assert_vs_at_field_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(fstate) == ST_F1 && fstate == ST_F2 && en) |=> vsync_o);
endmodule

// File: tb/sim_dtg_top.sv
module sim_dtg_top;
    import dtg_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0;
    logic cfg_interlace = 1'b0;
    logic [HW-1:0] cfg_h_total = '0, cfg_hs_start = '0, cfg_hs_width = '0;
    logic [HW-1:0] cfg_mark_pos = '0, cfg_hact_first = '0, cfg_hact_end = '0;
    logic [VW-1:0] cfg_v_total = '0, cfg_f1_last = '0;
    logic [VW-1:0] cfg_act1_first = '0, cfg_act1_end = '0, cfg_act2_first = '0, cfg_act2_end = '0;
    logic fid_o, vsync_o, vblank_o, hsync_o, hmark_o, actvid_o;

    int checks = 0;
    int fails = 0;
    string phase = "R1";
    logic [5:0] expq[$];

    int mh, mv, mfld, mfid;
    int s_il, s_ht, s_vt, s_f1, s_hss, s_hsw, s_mp, s_has, s_hae, s_a1f, s_a1e, s_a2f, s_a2e;

    always #2 clk = ~clk;

    dtg_top u0 (
        .clk(clk), .rst_n(rst_n), .en(en), .cfg_interlace(cfg_interlace),
        .cfg_h_total(cfg_h_total), .cfg_v_total(cfg_v_total), .cfg_f1_last(cfg_f1_last),
        .cfg_hs_start(cfg_hs_start), .cfg_hs_width(cfg_hs_width), .cfg_mark_pos(cfg_mark_pos),
        .cfg_hact_first(cfg_hact_first), .cfg_hact_end(cfg_hact_end),
        .cfg_act1_first(cfg_act1_first), .cfg_act1_end(cfg_act1_end),
        .cfg_act2_first(cfg_act2_first), .cfg_act2_end(cfg_act2_end),
        .fid_o(fid_o), .vsync_o(vsync_o), .vblank_o(vblank_o),
        .hsync_o(hsync_o), .hmark_o(hmark_o), .actvid_o(actvid_o)
    );

    task automatic load_shadow();
        s_il = int'(cfg_interlace); s_ht = int'(cfg_h_total); s_vt = int'(cfg_v_total);
        s_f1 = int'(cfg_f1_last); s_hss = int'(cfg_hs_start); s_hsw = int'(cfg_hs_width);
        s_mp = int'(cfg_mark_pos); s_has = int'(cfg_hact_first); s_hae = int'(cfg_hact_end);
        s_a1f = int'(cfg_act1_first); s_a1e = int'(cfg_act1_end);
        s_a2f = int'(cfg_act2_first); s_a2e = int'(cfg_act2_end);
    endtask

    // Reference model of one clock edge; pushes the strobes expected after it
    task automatic model();
        logic [5:0] e;
        bit f2, win, hl, vl, fe;
        if (!en) begin
            e = '0; mh = 0; mv = 0; mfld = 0; mfid = 0;
            load_shadow();
        end else begin
            f2 = (mfld == 2);
            win = f2 ? (mv >= s_a2f && mv < s_a2e) : (mv >= s_a1f && mv < s_a1e);
            e[5] = mfid[0];
            e[4] = (mv == 0) || (f2 && mv == s_f1 + 1);
            e[3] = !win;
            e[2] = (mh >= s_hss) && (mh < s_hss + s_hsw);
            e[1] = (mh >= s_mp) && (mh < s_mp + 4);
            e[0] = win && (mh >= s_has) && (mh < s_hae);
            hl = (mh == s_ht - 1); vl = (mv == s_vt - 1); fe = hl && vl;
            if (fe) begin mfld = 1; mfid ^= 1; load_shadow(); end
            else if (mfld == 1 && s_il != 0 && hl && mv == s_f1) begin mfld = 2; mfid ^= 1; end
            else if (mfld == 0) mfld = 1;
            if (hl) begin mh = 0; mv = vl ? 0 : mv + 1; end
            else mh = mh + 1;
        end
        expq.push_back(e);
    endtask

    task automatic step();
        @(posedge clk); #1; model(); @(negedge clk);
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    // Monitor: scoreboard compare, one check per clock (R4..R9, R11)
    always @(negedge clk) begin
        if (expq.size() > 0) begin
            logic [5:0] e, g;
            e = expq.pop_front();
            g = {fid_o, vsync_o, vblank_o, hsync_o, hmark_o, actvid_o};
            checks++;
            if (g !== e) begin
                fails++;
                $display("FAIL phase %s [R4 fid,R5 vsync,R6 vblank,R7 hsync,R8 hmark,R9 actvid; R11 timing] got %b exp %b",
                         phase, g, e);
            end
        end
    end

    task automatic set_prog();
        cfg_interlace = 1'b0; cfg_h_total = 16; cfg_v_total = 10; cfg_f1_last = 0;
        cfg_hs_start = 2; cfg_hs_width = 3; cfg_mark_pos = 10;
        cfg_hact_first = 4; cfg_hact_end = 14;
        cfg_act1_first = 2; cfg_act1_end = 8; cfg_act2_first = 0; cfg_act2_end = 0;
    endtask

    task automatic set_intl();
        cfg_interlace = 1'b1; cfg_h_total = 20; cfg_v_total = 12; cfg_f1_last = 5;
        cfg_hs_start = 0; cfg_hs_width = 5; cfg_mark_pos = 16;
        cfg_hact_first = 6; cfg_hact_end = 20;
        cfg_act1_first = 1; cfg_act1_end = 5; cfg_act2_first = 7; cfg_act2_end = 11;
    endtask

    initial begin
        #600000;
        fails++;
        checks++;
        $display("FAIL watchdog expired (R3 counters did not advance) got hung exp done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int prev, cnt;
        set_prog();
        repeat (3) @(negedge clk);
        checks++;
        if ({fid_o, vsync_o, vblank_o, hsync_o, hmark_o, actvid_o} !== 6'b0) begin
            fails++;
            $display("FAIL R1 outputs in reset got %b exp 000000",
                     {fid_o, vsync_o, vblank_o, hsync_o, hmark_o, actvid_o});
        end
        rst_n = 1'b1;
        phase = "R1";
        run(4);

        phase = "R6_prog";
        en = 1'b1;
        run(16 * 10 * 3);

        // R3: line period equals total pixels
        phase = "R3";
        prev = hsync_o; cnt = 0;
        for (int i = 0; i < 100 && !(prev == 0 && hsync_o == 1); i++) begin prev = hsync_o; step(); end
        prev = hsync_o;
        for (int i = 0; i < 100; i++) begin
            step(); cnt++;
            if (prev == 0 && hsync_o == 1) break;
            prev = hsync_o;
        end
        checks++;
        if (cnt != 16) begin
            fails++;
            $display("FAIL R3 line period got %0d exp 16", cnt);
        end

        // R10: rewrite mid-frame, takes effect next frame only
        phase = "R10";
        run(37);
        cfg_hs_start = 7; cfg_mark_pos = 0; cfg_act1_first = 0; cfg_act1_end = 10;
        run(16 * 10 * 2);

        // R2: disable in mid frame, restart at origin
        phase = "R2";
        run(23);
        en = 1'b0;
        run(5);
        set_intl();
        en = 1'b1;
        phase = "R5_intl";
        run(20 * 12 * 3);

        // Boundary: marker at line end, sync width 0, one-line windows
        phase = "R8_edge";
        cfg_mark_pos = 16; cfg_hs_width = 0; cfg_act1_first = 3; cfg_act1_end = 4;
        cfg_act2_first = 11; cfg_act2_end = 12; cfg_hact_first = 0;
        run(20 * 12 * 2 + 7);
        en = 1'b0;
        phase = "R2_off";
        run(4);
        set_prog();
        en = 1'b1;
        phase = "R4_prog";
        run(16 * 10 * 2);
        run(2);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule